// File: doc/BRIEF.md
# Clock Source Select Control Bank

This block is a bank of control words for several clock-source selectors. Each selector has a select field that picks its source and a gate bit that stops its clock. Software can change single bits without reading first. It writes to a set alias, which turns bits on, or to a clear alias, which turns bits off. The word can also be written directly at its base address.

A select value written to a word is held as staged. For most selectors, the staged value reaches the select output only when software writes a 1 to that selector's bit in a shared update register. Selectors built without an update bit take their staged select one cycle after it changes. The gate bit is active-low: a 0 enables the clock, and it acts with no update strobe. The outputs are plain registered control lines. They are meant to feed a glitch-free switching stage that sits outside this block.

Address map, in word addresses: the upper address bits pick the selector and the low two bits pick the view. View 0 is the control word, view 1 the set alias, view 2 the clear alias, and view 3 reserved. The selector index equal to the number of selectors, at view 0, is the update register.

Top module: `clksel_bank`

## Requirements
- R1: Synchronous active-high reset makes every select output 0 and every clock enable 0, and every control word reads 0x8000_0000 (gate bit 31 set, select field 0).
- R2: A write to the set alias (view 1) ORs the data into the word. Data bits that are 0 leave their bits unchanged.
- R3: A write to the clear alias (view 2) clears each word bit whose data bit is 1 and leaves the others unchanged.
- R4: A write to the base address (view 0) replaces the word. Only the select field (bits 10:8) and the gate bit (bit 31) are stored.
- R5: For a selector that has an update bit, the select output holds its value until a 1 is written to bit i of the update register. That write loads the staged field into the output at the same clock edge.
- R6: For a selector without an update bit (by default, selector 3), the select output takes the staged field one cycle after the word changes.
- R7: The clock enable of selector i is the inverse of its gate bit. It follows set and clear writes of bit 31 at the same edge, and the select output stays unchanged.
- R8: The update register reads 0. A 1 in an update bit affects only its own selector. Bits for selectors without an update bit, and bits beyond the selector count, have no effect.
- R9: A read returns, one cycle after the address, the stored word of a base address, with unstored bits as 0. The reserved view and the update register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 5 | Word address, used for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid one cycle after the address |
| sel_live | output | 12 | Select output per selector, 3 bits each, selector i at bits 3i+2:3i |
| clk_en | output | 4 | Clock enable per selector, the inverse of its gate bit |

## Verification
The hardest case to reach is a select output held at an old value while its staged word already has a newer one. The bench builds this on purpose. It changes a field in several steps through the set and clear aliases, and it checks the output after each step, before any update strobe. It then strobes only some of the selectors and confirms that the others keep their old values. It also sends update bits for the selector with no update bit and for indices past the selector count, and confirms that nothing moves.

// File: rtl/csb_pkg.sv
package csb_pkg;
  typedef enum logic [1:0] {
    VIEW_WORD = 2'd0,
    VIEW_SET  = 2'd1,
    VIEW_CLR  = 2'd2,
    VIEW_RSVD = 2'd3
  } csb_view_e;

  function automatic logic [63:0] csb_field_mask(input int shift, input int width);
    return ((64'd1 << width) - 64'd1) << shift;
  endfunction
endpackage

// File: rtl/csb_decode.sv
module csb_decode
  import csb_pkg::*;
#(
  parameter int NUM_SEL = 4,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_SEL-1:0] hit_word,
  output logic [NUM_SEL-1:0] hit_set,
  output logic [NUM_SEL-1:0] hit_clr,
  output logic               hit_upd
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  csb_view_e        view;

  always_comb begin
    idx  = addr[ADDR_W-1:2];
    view = csb_view_e'(addr[1:0]);
    for (int i = 0; i < NUM_SEL; i++) begin
      hit_word[i] = wr_en && (idx == IDX_W'(i)) && (view == VIEW_WORD);
      hit_set[i]  = wr_en && (idx == IDX_W'(i)) && (view == VIEW_SET);
      hit_clr[i]  = wr_en && (idx == IDX_W'(i)) && (view == VIEW_CLR);
    end
    hit_upd = wr_en && (idx == IDX_W'(NUM_SEL)) && (view == VIEW_WORD);
  end

  // R4: a single bus write reaches at most one target
  p_one_target_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_word, hit_set, hit_clr, hit_upd}));

  // R9: no write lands on the reserved view
  p_rsvd_inert_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[1:0] == 2'd3) |-> !(|{hit_word, hit_set, hit_clr, hit_upd}));
endmodule

// File: rtl/csb_slice.sv
module csb_slice #(
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 3,
  parameter int SEL_SHIFT = 8,
  parameter int GATE_BIT  = 31,
  parameter bit HAS_UPD   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_word,
  input  logic              wr_set,
  input  logic              wr_clr,
  input  logic              upd_strobe,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic              en_q
);
  localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'(csb_pkg::csb_field_mask(SEL_SHIFT, SEL_W));
  localparam logic [DATA_W-1:0] GATE_MASK  = DATA_W'(64'd1 << GATE_BIT);
  localparam logic [DATA_W-1:0] KEEP_MASK  = FIELD_MASK | GATE_MASK;
  localparam logic [DATA_W-1:0] RESET_WORD = GATE_MASK;

  logic [DATA_W-1:0] kept;
  logic [DATA_W-1:0] nxt;
  logic [SEL_W-1:0]  staged;

  always_comb begin
    kept = wdata & KEEP_MASK;
    nxt  = word_q;
    if (wr_word)     nxt = kept;
    else if (wr_set) nxt = word_q | kept;
    else if (wr_clr) nxt = word_q & ~kept;
  end

  assign staged = word_q[SEL_SHIFT +: SEL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= RESET_WORD;
      en_q   <= 1'b0;
    end else begin
      word_q <= nxt;
      en_q   <= ~nxt[GATE_BIT];
    end
  end

  generate
    if (HAS_UPD) begin : g_strobed
      always_ff @(posedge clk) begin
        if (rst)             sel_q <= '0;
        else if (upd_strobe) sel_q <= staged;
      end

      // R5: output holds without a strobe
      p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !upd_strobe |=> $stable(sel_q));
      // R5: strobe loads the staged field
      p_load_r5: assert property (@(posedge clk) disable iff (rst)
        upd_strobe |=> sel_q == $past(staged));
    end else begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else     sel_q <= staged;
      end

      // R6: output trails the staged field by one cycle; R8: strobe is irrelevant
      p_follow_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_strobe || !upd_strobe) |=> sel_q == $past(staged));
    end
  endgenerate

  // R2: bits written through the set alias end up 1
  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> (word_q & $past(kept)) == $past(kept));
  // R3: bits written through the clear alias end up 0
  p_clr_r3: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> (word_q & $past(kept)) == '0);
  // R7: gate set means clock disabled
  p_gate_off_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_set && wdata[GATE_BIT]) |=> !en_q);
  // R7: gate cleared means clock enabled
  p_gate_on_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && wdata[GATE_BIT]) |=> en_q);
  // R4: unstored bits never appear in the word
  p_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (word_q & ~KEEP_MASK) == '0);
endmodule

// File: rtl/csb_rdport.sv
module csb_rdport
  import csb_pkg::*;
#(
  parameter int NUM_SEL = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NUM_SEL*DATA_W-1:0] words,
  output logic [DATA_W-1:0]         rdata_q
);
  localparam int IDX_W = ADDR_W - 2;

  logic [DATA_W-1:0] pick;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    idx  = addr[ADDR_W-1:2];
    pick = '0;
    if (csb_view_e'(addr[1:0]) == VIEW_WORD) begin
      for (int i = 0; i < NUM_SEL; i++) begin
        if (idx == IDX_W'(i)) pick = words[i*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= pick;
  end

  // R8: the update register reads zero
  p_upd_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (addr[ADDR_W-1:2] == IDX_W'(NUM_SEL)) |=> rdata_q == '0);
  // R9: the reserved view reads zero
  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (addr[1:0] == 2'd3) |=> rdata_q == '0);
endmodule

// File: rtl/clksel_bank.sv
module clksel_bank #(
  parameter int              NUM_SEL   = 4,
  parameter int              DATA_W    = 32,
  parameter int              SEL_W     = 3,
  parameter int              SEL_SHIFT = 8,
  parameter int              GATE_BIT  = 31,
  parameter logic [NUM_SEL-1:0] UPD_MASK = 4'b0111,
  parameter int              ADDR_W    = $clog2(NUM_SEL + 1) + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic [NUM_SEL*SEL_W-1:0] sel_live,
  output logic [NUM_SEL-1:0]       clk_en
);
  logic [NUM_SEL-1:0]        hit_word;
  logic [NUM_SEL-1:0]        hit_set;
  logic [NUM_SEL-1:0]        hit_clr;
  logic                      hit_upd;
  logic [NUM_SEL*DATA_W-1:0] words;

  csb_decode #(.NUM_SEL(NUM_SEL), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr),
    .hit_word(hit_word), .hit_set(hit_set), .hit_clr(hit_clr), .hit_upd(hit_upd)
  );

  generate
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
      csb_slice #(
        .DATA_W(DATA_W), .SEL_W(SEL_W), .SEL_SHIFT(SEL_SHIFT),
        .GATE_BIT(GATE_BIT), .HAS_UPD(UPD_MASK[i])
      ) u_slice (
        .clk(clk), .rst(rst),
        .wr_word(hit_word[i]), .wr_set(hit_set[i]), .wr_clr(hit_clr[i]),
        .upd_strobe(hit_upd && bus_wdata[i]),
        .wdata(bus_wdata),
        .word_q(words[i*DATA_W +: DATA_W]),
        .sel_q(sel_live[i*SEL_W +: SEL_W]),
        .en_q(clk_en[i])
      );
    end
  endgenerate

  csb_rdport #(.NUM_SEL(NUM_SEL), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .addr(bus_addr), .words(words), .rdata_q(bus_rdata)
  );

  // R1: reset leaves every clock gated and every select at zero
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (clk_en == '0) && (sel_live == '0));
endmodule

// File: tb/sim_clksel_bank.sv
module sim_clksel_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] sel_live;
  logic [3:0]  clk_en;
  int checks = 0;
  int errors = 0;

  clksel_bank u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sel_live(sel_live), .clk_en(clk_en)
  );

  always #10 clk = ~clk;

  function automatic logic [4:0] adr(input int sel, input int view);
    return 5'(sel * 4 + view);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] live(input int i);
    return 32'(sel_live[i*3 +: 3]);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 sel_live", 32'(sel_live), 0);
    chk("R1 clk_en", 32'(clk_en), 0);
    rd(adr(0, 0), v); chk("R1 word0", v, 32'h8000_0000);
    rd(adr(3, 0), v); chk("R1 word3", v, 32'h8000_0000);
  endtask

  task automatic t_set_clr();
    logic [31:0] v;
    wr(adr(1, 1), 32'h0000_0500);
    rd(adr(1, 0), v); chk("R2 set 5", v, 32'h8000_0500);
    wr(adr(1, 1), 32'h0000_0200);
    rd(adr(1, 0), v); chk("R2 set or", v, 32'h8000_0700);
    wr(adr(1, 2), 32'h0000_0300);
    rd(adr(1, 0), v); chk("R3 clear", v, 32'h8000_0400);
    chk("R5 live1 held", live(1), 0);
  endtask

  task automatic t_update();
    wr(adr(4, 0), 32'h0000_0002);
    chk("R5 live1 loaded", live(1), 4);
    chk("R8 live0 untouched", live(0), 0);
    chk("R8 live2 untouched", live(2), 0);
  endtask

  task automatic t_noupd();
    wr(adr(3, 1), 32'h0000_0600);
    chk("R6 live3 not yet", live(3), 0);
    @(negedge clk);
    chk("R6 live3 follows", live(3), 6);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    wr(adr(2, 2), 32'h8000_0000);
    chk("R7 enable", 32'(clk_en[2]), 1);
    chk("R7 sel unchanged", live(2), 0);
    rd(adr(2, 0), v); chk("R7 word", v, 32'h0000_0000);
    wr(adr(2, 1), 32'h8000_0000);
    chk("R7 disable", 32'(clk_en[2]), 0);
  endtask

  task automatic t_direct();
    logic [31:0] v;
    wr(adr(0, 0), 32'h1234_5678);
    rd(adr(0, 0), v); chk("R4 direct masked", v, 32'h0000_0600);
    chk("R4 gate from direct", 32'(clk_en[0]), 1);
    chk("R5 live0 held", live(0), 0);
  endtask

  task automatic t_upd_read();
    logic [31:0] v;
    rd(adr(4, 0), v); chk("R8 upd reads 0", v, 0);
    rd(adr(0, 3), v); chk("R9 rsvd reads 0", v, 0);
    wr(adr(4, 0), 32'h0000_0001);
    chk("R8 live0 loaded", live(0), 6);
    chk("R8 live1 kept", live(1), 4);
    wr(adr(1, 1), 32'h0000_0300);
    wr(adr(4, 0), 32'hFFFF_FFF8);
    chk("R8 high bits inert live1", live(1), 4);
    chk("R8 high bits inert live0", live(0), 6);
  endtask

  task automatic t_recipe();
    wr(adr(2, 2), 32'h0000_0700);
    wr(adr(2, 1), 32'h0000_0300);
    chk("R5 recipe held", live(2), 0);
    wr(adr(4, 0), 32'h0000_0004);
    chk("R5 recipe loaded", live(2), 3);
    chk("R7 still gated", 32'(clk_en[2]), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_set_clr();
    t_update();
    t_noupd();
    t_gate();
    t_direct();
    t_upd_read();
    t_recipe();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule